// File: doc/BRIEF.md
# Strided Two-Dimensional Copy Engine with In-Flight Reduce

This block moves a two-dimensional tensor between two regions of one memory. Each side of the transfer (the read leg and the write leg) is described by a base byte address, two element counts and two signed byte steps. The engine visits elements one after another, with the inner dimension (index 0) running fastest. The two legs advance in lockstep, so their shapes may differ as long as the element totals agree. Each element is one memory word. It is either copied, or combined with the word already at the destination by an add, multiply, maximum or minimum.

A command is presented on the command inputs together with a one-cycle `start`. The engine first checks the command. It then waits until a semaphore condition holds, comparing the current semaphore level with an immediate or a register value. After that it walks the element pairs. Every address is checked against a per-leg `[lo, hi)` window before it is used. When the walk ends normally, the engine raises a completion pulse that carries a semaphore index and a nonzero increment. The memory port is a plain synchronous single-port RAM interface with a read latency of one cycle.

Top module: `stride_mover`

## Requirements
- R1: With reduce code NONE (0) the word read at each source element is written unchanged to the paired destination element. Within each leg, index 0 runs from 0 to count0-1 before index 1 advances. The element address is base + i0*step0 + i1*step1, modulo 2^32.
- R2: Steps are two's-complement 32-bit values, so a negative step walks a leg toward lower addresses.
- R3: Reduce codes ADD (1), MULTIPLY (2), MAX (3) and MIN (4) write dst+src, the low 32 bits of dst*src, the unsigned larger value and the unsigned smaller value respectively, where dst is the word read from the destination element just before the write.
- R4: A command is rejected if its reduce code is 5 to 7. It is also rejected if the reduce code is not NONE and any base or step of either leg is not a multiple of the 4-byte word, or either leg's element size is not 4. With reduce code NONE these alignment and size checks are not applied. A rejected command makes no memory access, sets err, pulses done in the cycle after start and gives no increment.
- R5: A command whose leg totals (count0*count1) differ is rejected in the same way as in R4. A command whose totals are both zero completes with no memory access and with the normal increment.
- R6: Wait mode 0x00 does not wait. Modes 0x01..0x05 compare the semaphore level with the immediate as EQ, LT, LE, GT, GE (level on the left, unsigned). Modes 0x81..0x85 perform the same compares against the register value. The engine stays busy and makes no access until the compare holds. Any other mode code rejects the command.
- R7: If, before an element is touched, its source address lies outside [src_lo, src_hi) or its destination address lies outside [dst_lo, dst_hi), the transfer stops at once. Earlier elements stay written, err is set and no increment is given.
- R8: On normal completion, sem_inc pulses in the done cycle with sem_inc_idx equal to the command's semaphore index and sem_inc_val equal to its 8-bit increment. There is no pulse when the increment is zero.
- R9: done is a one-cycle pulse. busy is high from the cycle after an accepted start until done. A start while busy is ignored.
- R10: After reset, busy, done, err, sem_inc, mem_re and mem_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| src_base | input | 32 | Source leg base byte address |
| src_step0 | input | 32 | Source inner step, signed bytes |
| src_step1 | input | 32 | Source outer step, signed bytes |
| src_cnt0 | input | 16 | Source inner element count |
| src_cnt1 | input | 16 | Source outer element count |
| src_esize | input | 16 | Source element size in bytes |
| src_lo | input | 32 | Source window low bound (inclusive) |
| src_hi | input | 32 | Source window high bound (exclusive) |
| dst_base | input | 32 | Destination leg base byte address |
| dst_step0 | input | 32 | Destination inner step, signed bytes |
| dst_step1 | input | 32 | Destination outer step, signed bytes |
| dst_cnt0 | input | 16 | Destination inner element count |
| dst_cnt1 | input | 16 | Destination outer element count |
| dst_esize | input | 16 | Destination element size in bytes |
| dst_lo | input | 32 | Destination window low bound (inclusive) |
| dst_hi | input | 32 | Destination window high bound (exclusive) |
| red_op | input | 3 | Reduce code (0 none, 1 add, 2 multiply, 3 max, 4 min) |
| wait_mode | input | 8 | Wait condition code |
| wait_imm | input | 32 | Immediate compare threshold |
| sem_level | input | 32 | Current level of the awaited semaphore |
| reg_val | input | 32 | Register compare threshold |
| sem_sel | input | 8 | Completion semaphore index |
| sem_inc_amt | input | 8 | Completion increment |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last command rejected or aborted |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_re |
| sem_inc | output | 1 | Completion semaphore increment pulse |
| sem_inc_idx | output | 8 | Semaphore index for the increment |
| sem_inc_val | output | 8 | Increment amount |

## Verification
The hardest situation to reach is a bounds abort in the middle of a walk. A window edge has to fall exactly between two legal elements of a row-wrapping walk, so that some writes have already landed when the stop happens. The bench narrows the destination window to cut off the fifth element of a 3x3 walk, and raises the source low bound past the first element. A reference walk in the bench predicts which words change. The wait stall is held open for many cycles while a second start arrives, and is then released through the semaphore level, to show that the stall blocks all memory traffic and that the stray start changes nothing.

// File: rtl/stride_mover_pkg.sv
package stride_mover_pkg;
  typedef enum logic [2:0] {
    RED_NONE = 3'd0,
    RED_ADD  = 3'd1,
    RED_MUL  = 3'd2,
    RED_MAX  = 3'd3,
    RED_MIN  = 3'd4
  } red_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SRC, ST_DST, ST_WR, ST_DONE
  } mover_state_e;

  // legal codes: 0x00, 0x01..0x05, 0x81..0x85
  function automatic logic wait_mode_legal(input logic [7:0] m);
    return (m == 8'h00) || ((m[6:3] == 4'd0) && (m[2:0] >= 3'd1) && (m[2:0] <= 3'd5));
  endfunction
endpackage

// File: rtl/stride_mover_walk.sv
module stride_mover_walk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step0,
  input  logic [AW-1:0] step1,
  input  logic [CW-1:0] cnt0,
  input  logic [CW-1:0] cnt1,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [CW-1:0] i0, i1, n0, n1;
  logic [AW-1:0] s0, s1, row;

  always_ff @(posedge clk) begin
    if (rst) begin
      i0 <= '0; i1 <= '0; n0 <= '0; n1 <= '0;
      s0 <= '0; s1 <= '0; row <= '0; addr <= '0;
    end else if (load) begin
      i0 <= '0; i1 <= '0; n0 <= cnt0; n1 <= cnt1;
      s0 <= step0; s1 <= step1; row <= base; addr <= base;
    end else if (adv) begin
      if (i0 == n0 - CW'(1)) begin
        i0   <= '0;
        i1   <= i1 + CW'(1);
        row  <= row + s1;
        addr <= row + s1;
      end else begin
        i0   <= i0 + CW'(1);
        addr <= addr + s0;
      end
    end
  end

  assign last = (i0 == n0 - CW'(1)) && (i1 == n1 - CW'(1));
endmodule

// File: rtl/stride_mover_wait.sv
module stride_mover_wait #(
  parameter int VW = 32
) (
  input  logic [7:0]    mode,
  input  logic [VW-1:0] imm,
  input  logic [VW-1:0] regv,
  input  logic [VW-1:0] level,
  output logic          pass
);
  logic [VW-1:0] thr;
  assign thr = mode[7] ? regv : imm;

  always_comb begin
    unique case (mode[2:0])
      3'd1:    pass = (level == thr);
      3'd2:    pass = (level <  thr);
      3'd3:    pass = (level <= thr);
      3'd4:    pass = (level >  thr);
      3'd5:    pass = (level >= thr);
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/stride_mover_alu.sv
module stride_mover_alu import stride_mover_pkg::*; #(
  parameter int DW = 32
) (
  input  red_op_e       op,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      RED_ADD: y = dst + src;
      RED_MUL: y = dst * src;
      RED_MAX: y = (src > dst) ? src : dst;
      RED_MIN: y = (src < dst) ? src : dst;
      default: y = src;
    endcase
  end
endmodule

// File: rtl/stride_mover.sv
module stride_mover import stride_mover_pkg::*; #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int SZW  = 16,
  parameter int VW   = 32,
  parameter int SEMW = 8,
  parameter int INCW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   src_step0,
  input  logic [AW-1:0]   src_step1,
  input  logic [CW-1:0]   src_cnt0,
  input  logic [CW-1:0]   src_cnt1,
  input  logic [SZW-1:0]  src_esize,
  input  logic [AW-1:0]   src_lo,
  input  logic [AW-1:0]   src_hi,
  input  logic [AW-1:0]   dst_base,
  input  logic [AW-1:0]   dst_step0,
  input  logic [AW-1:0]   dst_step1,
  input  logic [CW-1:0]   dst_cnt0,
  input  logic [CW-1:0]   dst_cnt1,
  input  logic [SZW-1:0]  dst_esize,
  input  logic [AW-1:0]   dst_lo,
  input  logic [AW-1:0]   dst_hi,
  input  logic [2:0]      red_op,
  input  logic [7:0]      wait_mode,
  input  logic [VW-1:0]   wait_imm,
  input  logic [VW-1:0]   sem_level,
  input  logic [VW-1:0]   reg_val,
  input  logic [SEMW-1:0] sem_sel,
  input  logic [INCW-1:0] sem_inc_amt,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            mem_re,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            sem_inc,
  output logic [SEMW-1:0] sem_inc_idx,
  output logic [INCW-1:0] sem_inc_val
);
  localparam int            WB    = DW / 8;
  localparam int            TW    = 2 * CW;
  localparam logic [AW-1:0] AMASK = AW'(WB - 1);

  mover_state_e    state;
  red_op_e         op_q;
  logic [7:0]      mode_q;
  logic [VW-1:0]   imm_q;
  logic [SEMW-1:0] sel_q;
  logic [INCW-1:0] inc_q;
  logic [AW-1:0]   slo_q, shi_q, dlo_q, dhi_q;
  logic [DW-1:0]   sdat_q;
  logic            err_q, empty_q;

  // command screening on the live inputs
  logic [TW-1:0] tot_s, tot_d;
  logic          op_ok, align_ok, size_ok, cmd_ok, accept;
  assign tot_s    = TW'(src_cnt0) * TW'(src_cnt1);
  assign tot_d    = TW'(dst_cnt0) * TW'(dst_cnt1);
  assign op_ok    = (red_op <= 3'd4);
  assign align_ok = ((src_base | src_step0 | src_step1 |
                      dst_base | dst_step0 | dst_step1) & AMASK) == '0;
  assign size_ok  = (src_esize == SZW'(WB)) && (dst_esize == SZW'(WB));
  assign cmd_ok   = op_ok && wait_mode_legal(wait_mode) && (tot_s == tot_d) &&
                    ((red_op == 3'd0) || (align_ok && size_ok));
  assign accept   = (state == ST_IDLE) && start;

  // address legs
  logic [AW-1:0] s_addr, d_addr;
  logic          s_last, d_last, adv;
  assign adv = (state == ST_WR);

  stride_mover_walk #(.AW(AW), .CW(CW)) u_src_leg (
    .clk(clk), .rst(rst), .load(accept), .adv(adv),
    .base(src_base), .step0(src_step0), .step1(src_step1),
    .cnt0(src_cnt0), .cnt1(src_cnt1), .addr(s_addr), .last(s_last)
  );

  stride_mover_walk #(.AW(AW), .CW(CW)) u_dst_leg (
    .clk(clk), .rst(rst), .load(accept), .adv(adv),
    .base(dst_base), .step0(dst_step0), .step1(dst_step1),
    .cnt0(dst_cnt0), .cnt1(dst_cnt1), .addr(d_addr), .last(d_last)
  );

  logic wait_pass;
  stride_mover_wait #(.VW(VW)) u_wait (
    .mode(mode_q), .imm(imm_q), .regv(reg_val), .level(sem_level), .pass(wait_pass)
  );

  logic [DW-1:0] alu_src, alu_y;
  assign alu_src = (op_q == RED_NONE) ? mem_rdata : sdat_q;
  stride_mover_alu #(.DW(DW)) u_alu (
    .op(op_q), .src(alu_src), .dst(mem_rdata), .y(alu_y)
  );

  logic s_in, d_in, both_in;
  assign s_in    = (s_addr >= slo_q) && (s_addr < shi_q);
  assign d_in    = (d_addr >= dlo_q) && (d_addr < dhi_q);
  assign both_in = s_in && d_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      op_q <= RED_NONE; mode_q <= '0; imm_q <= '0; sel_q <= '0; inc_q <= '0;
      slo_q <= '0; shi_q <= '0; dlo_q <= '0; dhi_q <= '0;
      sdat_q <= '0; err_q <= 1'b0; empty_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          op_q    <= red_op_e'(red_op);
          mode_q  <= wait_mode;
          imm_q   <= wait_imm;
          sel_q   <= sem_sel;
          inc_q   <= sem_inc_amt;
          slo_q   <= src_lo; shi_q <= src_hi;
          dlo_q   <= dst_lo; dhi_q <= dst_hi;
          empty_q <= (tot_s == '0);
          err_q   <= !cmd_ok;
          state   <= cmd_ok ? ST_WAIT : ST_DONE;
        end
        ST_WAIT: if (wait_pass) state <= empty_q ? ST_DONE : ST_SRC;
        ST_SRC: begin
          if (!both_in) begin
            err_q <= 1'b1;
            state <= ST_DONE;
          end else begin
            state <= (op_q == RED_NONE) ? ST_WR : ST_DST;
          end
        end
        ST_DST: begin
          sdat_q <= mem_rdata;
          state  <= ST_WR;
        end
        ST_WR:   state <= (s_last && d_last) ? ST_DONE : ST_SRC;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_DONE);
  assign err         = err_q;
  assign mem_re      = ((state == ST_SRC) && both_in) || (state == ST_DST);
  assign mem_we      = (state == ST_WR);
  assign mem_addr    = (state == ST_SRC) ? s_addr : d_addr;
  assign mem_wdata   = alu_y;
  assign sem_inc     = done && !err_q && (inc_q != '0);
  assign sem_inc_idx = sel_q;
  assign sem_inc_val = inc_q;
endmodule

// File: rtl/stride_mover_chk.sv
module stride_mover_chk #(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int INCW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            sem_inc,
  input logic [INCW-1:0] sem_inc_val,
  input logic            mem_re,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [AW-1:0]   src_lo,
  input logic [AW-1:0]   src_hi,
  input logic [AW-1:0]   dst_lo,
  input logic [AW-1:0]   dst_hi,
  input logic [CW-1:0]   src_cnt0,
  input logic [CW-1:0]   src_cnt1,
  input logic [CW-1:0]   dst_cnt0,
  input logic [CW-1:0]   dst_cnt1
);
  logic [2*CW-1:0] ts, td;
  assign ts = (2*CW)'(src_cnt0) * (2*CW)'(src_cnt1);
  assign td = (2*CW)'(dst_cnt0) * (2*CW)'(dst_cnt1);

  p_reject_mismatch_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (ts != td)) |=> (done && err));

  p_wr_window_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_addr >= dst_lo) && (mem_addr < dst_hi)));

  p_rd_window_r7: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (((mem_addr >= src_lo) && (mem_addr < src_hi)) ||
                ((mem_addr >= dst_lo) && (mem_addr < dst_hi))));

  p_abort_no_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> !sem_inc);

  p_inc_rules_r8: assert property (@(posedge clk) disable iff (rst)
    sem_inc |-> (done && (sem_inc_val != '0)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_re && !mem_we));

  p_no_rw_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
endmodule

bind stride_mover stride_mover_chk #(.AW(AW), .CW(CW), .INCW(INCW)) u_chk (.*);

// File: tb/stride_mover_test.sv
module stride_mover_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_base, src_step0, src_step1, src_lo, src_hi;
  logic [15:0] src_cnt0, src_cnt1, src_esize;
  logic [31:0] dst_base, dst_step0, dst_step1, dst_lo, dst_hi;
  logic [15:0] dst_cnt0, dst_cnt1, dst_esize;
  logic [2:0]  red_op;
  logic [7:0]  wait_mode;
  logic [31:0] wait_imm, sem_level, reg_val;
  logic [7:0]  sem_sel, sem_inc_amt;
  logic        busy, done, err, mem_re, mem_we, sem_inc;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  sem_inc_idx, sem_inc_val;

  always #4 clk = ~clk;  // 8 ns period

  stride_mover uut (.*);

  // synchronous RAM model, word index = byte address bits [9:2]
  logic [31:0] ram [0:255];
  logic [31:0] exp_mem [0:255];
  logic        init_now = 1'b0;

  function automatic logic [31:0] pat(input int i);
    return 32'(i * 37 + 11) ^ ((i % 2 == 1) ? 32'h8000_0000 : 32'h0);
  endfunction

  always @(posedge clk) begin
    if (init_now) begin
      for (int i = 0; i < 256; i++) ram[i] <= pat(i);
    end else begin
      if (mem_we) ram[mem_addr[9:2]] <= mem_wdata;
      if (mem_re) mem_rdata <= ram[mem_addr[9:2]];
    end
  end

  int wr_cnt = 0, inc_cnt = 0, done_cnt = 0;
  logic [7:0] last_idx = 8'h0, last_val = 8'h0;
  always @(posedge clk) begin
    if (mem_we) wr_cnt <= wr_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (sem_inc) begin
      inc_cnt  <= inc_cnt + 1;
      last_idx <= sem_inc_idx;
      last_val <= sem_inc_val;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    src_base = 32'h100; src_step0 = 32'd4; src_step1 = 32'd16;
    src_cnt0 = 16'd2; src_cnt1 = 16'd2; src_esize = 16'd4;
    src_lo = 32'h0; src_hi = 32'h400;
    dst_base = 32'h200; dst_step0 = 32'd4; dst_step1 = 32'd16;
    dst_cnt0 = 16'd2; dst_cnt1 = 16'd2; dst_esize = 16'd4;
    dst_lo = 32'h0; dst_hi = 32'h400;
    red_op = 3'd0; wait_mode = 8'h00; wait_imm = 32'd0;
    sem_level = 32'd0; reg_val = 32'd0;
    sem_sel = 8'h2a; sem_inc_amt = 8'd3;
  endtask

  task automatic init_mem();
    @(negedge clk) init_now = 1'b1;
    @(negedge clk) init_now = 1'b0;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
  endtask

  function automatic int mismatches();
    int n = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  // reference walk from the requirements
  task automatic ref_run(output bit rerr, output int nwr);
    int t;
    int si0 = 0, si1 = 0, di0 = 0, di1 = 0;
    logic [31:0] sa, da, s, d;
    t = int'(src_cnt0) * int'(src_cnt1);
    rerr = 1'b0; nwr = 0;
    for (int k = 0; k < t; k++) begin
      sa = src_base + 32'(si0) * src_step0 + 32'(si1) * src_step1;
      da = dst_base + 32'(di0) * dst_step0 + 32'(di1) * dst_step1;
      if (sa < src_lo || sa >= src_hi || da < dst_lo || da >= dst_hi) begin
        rerr = 1'b1;
        return;
      end
      s = exp_mem[sa[9:2]];
      d = exp_mem[da[9:2]];
      case (red_op)
        3'd1: d = d + s;
        3'd2: d = d * s;
        3'd3: d = (s > d) ? s : d;
        3'd4: d = (s < d) ? s : d;
        default: d = s;
      endcase
      exp_mem[da[9:2]] = d;
      nwr++;
      si0++; if (si0 == int'(src_cnt0)) begin si0 = 0; si1++; end
      di0++; if (di0 == int'(dst_cnt0)) begin di0 = 0; di1++; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit e, output int cyc);
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    e = err;
    if (!done) chk(1'b0, "R9 done timeout", cyc, 0);
    @(negedge clk);
  endtask

  task automatic fire(output bit e, output int cyc);
    pulse_start();
    wait_done(e, cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit e, rerr;
    int cyc, nwr, w0, i0, d0;
    defaults();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !sem_inc && !mem_re && !mem_we, "R10 reset outputs",
        {busy, done, err, sem_inc, mem_re, mem_we}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R3 sweep: every reduce code over small shapes, transposed destination shape
    for (int op = 0; op < 5; op++) begin
      for (int a0 = 1; a0 <= 3; a0++) begin
        for (int a1 = 1; a1 <= 3; a1++) begin
          defaults();
          red_op = 3'(op);
          src_cnt0 = 16'(a0); src_cnt1 = 16'(a1);
          dst_cnt0 = 16'(a1); dst_cnt1 = 16'(a0);
          init_mem();
          ref_run(rerr, nwr);
          i0 = inc_cnt;
          fire(e, cyc);
          chk(mismatches() == 0, op == 0 ? "R1 copy contents" : "R3 reduce contents",
              mismatches(), 0);
          chk(!e && inc_cnt == i0 + 1 && last_idx == 8'h2a && last_val == 8'd3,
              "R8 completion increment", {e, 8'(inc_cnt - i0), last_idx, last_val},
              {1'b0, 8'd1, 8'h2a, 8'd3});
        end
      end
    end

    // R9 done lasts one cycle (sampled just after the loop exit)
    chk(!done, "R9 done single cycle", done, 0);

    // R2 reverse source walk, copy
    defaults();
    src_base = 32'h1F0; src_step0 = 32'hFFFF_FFFC; src_step1 = 32'hFFFF_FFF0;
    src_cnt0 = 16'd3; src_cnt1 = 16'd3; dst_cnt0 = 16'd3; dst_cnt1 = 16'd3;
    dst_step1 = 32'd12;
    init_mem(); ref_run(rerr, nwr); fire(e, cyc);
    chk(mismatches() == 0 && !e, "R2 reverse source copy", mismatches(), 0);

    // R2 reverse both legs with ADD
    dst_base = 32'h2F0; dst_step0 = 32'hFFFF_FFFC; dst_step1 = 32'hFFFF_FFF4;
    red_op = 3'd1;
    init_mem(); ref_run(rerr, nwr); fire(e, cyc);
    chk(mismatches() == 0 && !e, "R2 reverse both legs add", mismatches(), 0);

    // R4 misaligned base with reduce: rejected
    defaults(); red_op = 3'd1; src_base = 32'h102;
    init_mem(); w0 = wr_cnt; i0 = inc_cnt; fire(e, cyc);
    chk(e && wr_cnt == w0 && inc_cnt == i0 && cyc <= 2, "R4 misaligned reduce rejected",
        {e, 8'(wr_cnt - w0), 8'(cyc)}, {1'b1, 8'd0, 8'd1});
    // R4 bad element size with reduce
    defaults(); red_op = 3'd2; dst_esize = 16'd2;
    w0 = wr_cnt; fire(e, cyc);
    chk(e && wr_cnt == w0, "R4 element size rejected", e, 1);
    // R4 misaligned step with reduce
    defaults(); red_op = 3'd4; dst_step1 = 32'd6;
    w0 = wr_cnt; fire(e, cyc);
    chk(e && wr_cnt == w0, "R4 misaligned step rejected", e, 1);
    // R4 no alignment check for plain copy
    defaults(); src_base = 32'h102; src_esize = 16'd2;
    init_mem(); ref_run(rerr, nwr); fire(e, cyc);
    chk(!e && mismatches() == 0, "R4 copy skips alignment check", e, 0);
    // R4 reduce codes 5..7 rejected
    for (int op = 5; op < 8; op++) begin
      defaults(); red_op = 3'(op);
      w0 = wr_cnt; fire(e, cyc);
      chk(e && wr_cnt == w0, "R4 unknown reduce code rejected", e, 1);
    end

    // R5 total mismatch
    defaults(); dst_cnt0 = 16'd3; dst_cnt1 = 16'd1;
    w0 = wr_cnt; i0 = inc_cnt; fire(e, cyc);
    chk(e && wr_cnt == w0 && inc_cnt == i0, "R5 count mismatch rejected",
        {e, 8'(wr_cnt - w0)}, {1'b1, 8'd0});
    // R5 empty transfer completes with increment
    defaults(); src_cnt0 = 16'd0; dst_cnt1 = 16'd0;
    w0 = wr_cnt; i0 = inc_cnt; fire(e, cyc);
    chk(!e && wr_cnt == w0 && inc_cnt == i0 + 1, "R5 empty transfer",
        {e, 8'(wr_cnt - w0), 8'(inc_cnt - i0)}, {1'b0, 8'd0, 8'd1});

    // R6 wait EQ immediate, with a stray start while blocked (R9)
    defaults(); wait_mode = 8'h01; wait_imm = 32'd5; sem_level = 32'd0;
    init_mem(); ref_run(rerr, nwr);
    w0 = wr_cnt; i0 = inc_cnt; d0 = done_cnt;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(busy && wr_cnt == w0, "R6 blocked on wait", {busy, 8'(wr_cnt - w0)}, {1'b1, 8'd0});
    pulse_start();
    repeat (5) @(negedge clk);
    chk(busy && !err && wr_cnt == w0, "R9 start while busy ignored", {busy, err}, 2'b10);
    sem_level = 32'd5;
    wait_done(e, cyc);
    repeat (3) @(negedge clk);
    chk(!e && mismatches() == 0 && done_cnt == d0 + 1 && inc_cnt == i0 + 1,
        "R6 released by level", {e, 8'(done_cnt - d0)}, {1'b0, 8'd1});

    // R6 GT against register
    defaults(); wait_mode = 8'h84; sem_level = 32'd3; reg_val = 32'd7;
    w0 = wr_cnt; pulse_start();
    repeat (10) @(negedge clk);
    chk(busy && wr_cnt == w0, "R6 register compare blocks", busy, 1);
    reg_val = 32'd2;
    wait_done(e, cyc);
    chk(!e && wr_cnt == w0 + 4, "R6 register compare releases", wr_cnt - w0, 4);

    // R6 LE immediate already true
    defaults(); wait_mode = 8'h03; wait_imm = 32'd9; sem_level = 32'd9;
    fire(e, cyc);
    chk(!e && cyc < 20, "R6 LE immediate passes", cyc, 1);

    // R6 illegal modes
    defaults(); wait_mode = 8'h06; fire(e, cyc);
    chk(e, "R6 mode 0x06 rejected", e, 1);
    defaults(); wait_mode = 8'h80; fire(e, cyc);
    chk(e, "R6 mode 0x80 rejected", e, 1);

    // R7 destination window cut mid-walk: fifth element out
    defaults(); src_cnt0 = 16'd3; src_cnt1 = 16'd3; dst_cnt0 = 16'd3; dst_cnt1 = 16'd3;
    dst_hi = 32'h214;
    init_mem(); ref_run(rerr, nwr);
    w0 = wr_cnt; i0 = inc_cnt; fire(e, cyc);
    chk(e && rerr && nwr == 4 && wr_cnt == w0 + 4 && inc_cnt == i0,
        "R7 destination bound abort", {e, 8'(wr_cnt - w0), 8'(inc_cnt - i0)},
        {1'b1, 8'd4, 8'd0});
    chk(mismatches() == 0, "R7 partial contents", mismatches(), 0);
    // R7 source low bound excludes first element
    defaults(); src_lo = 32'h104;
    init_mem(); w0 = wr_cnt; fire(e, cyc);
    chk(e && wr_cnt == w0 && mismatches() == 0, "R7 source bound abort",
        {e, 8'(wr_cnt - w0)}, {1'b1, 8'd0});

    // R8 zero increment gives no pulse
    defaults(); sem_inc_amt = 8'd0;
    i0 = inc_cnt; d0 = done_cnt; fire(e, cyc);
    chk(!e && inc_cnt == i0 && done_cnt == d0 + 1, "R8 zero increment no pulse",
        8'(inc_cnt - i0), 0);
    // R8 index and amount carried
    defaults(); sem_sel = 8'h07; sem_inc_amt = 8'hff;
    fire(e, cyc);
    chk(last_idx == 8'h07 && last_val == 8'hff, "R8 index and amount",
        {last_idx, last_val}, 16'h07ff);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule